// File: doc/BRIEF.md
# Segmented Logical-to-Physical Address Generator

This block forms the memory address for a 32-bit processor whose external address bus is only 24 bits wide. Each request carries three effective-address terms: a base, an index and a displacement. It also names a segment in two ways. A 16-bit selector value is used in real mode. A 3-bit slot number picks one of six loaded 32-bit segment bases in protected mode. The block returns the 32-bit linear address, the 24-bit physical address and a flag that tells a downstream paging unit whether it has to translate the result.

In real mode the selector is multiplied by sixteen and added to the effective address. The result is kept to 20 bits, so an address past 1 MB wraps to zero, and real mode never asks for paging. In protected mode the selected base is added to the effective address modulo 2^32. If paging is off, the physical bus uses the low 24 bits. If paging is on, the full linear address goes on with the paging flag set. Every output is a byte address. For a multi-byte access it is the address of the lowest-order byte.

The segment bases are written through a one-register-per-cycle load port. The block has one register stage: a request is sampled when `in_valid_i` is high, and its result appears with `out_valid_o` on the next clock.

Top module: `seg_agen`

## Requirements
- R1: The effective address is base + index + displacement modulo 2^32; when `use_index_i` is 0 the index term counts as zero.
- R2: In real mode (`prot_mode_i`=0) the linear address is ((selector << 4) + effective address) modulo 2^20, with bits 31..20 zero.
- R3: In protected mode (`prot_mode_i`=1) the linear address is (segment base of slot `seg_idx_i` + effective address) modulo 2^32; slot numbers 6 and 7 read a base of zero.
- R4: `phys_o` always equals bits 23..0 of `linear_o`.
- R5: `needs_paging_o` is 1 exactly when the sampled request was in protected mode with `paging_en_i`=1; a real-mode request never sets it.
- R6: `out_valid_o` is high exactly one cycle after `in_valid_i` was high; when `in_valid_i` is low the address and flag outputs keep their values.
- R7: With `base_we_i`=1, slot `base_widx_i` (0..5) takes `base_wdata_i` at the clock edge; slot numbers 6 and 7 are ignored; a translation in the same cycle as a write to its slot uses the old base.
- R8: While `rst_ni` is low, `out_valid_o`, `linear_o`, `phys_o`, `needs_paging_o` and all six bases are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request strobe |
| prot_mode_i | input | 1 | 1 = protected mode, 0 = real mode |
| paging_en_i | input | 1 | Paging enabled |
| seg_idx_i | input | 3 | Segment base slot used in protected mode |
| selector_i | input | 16 | Segment selector value used in real mode |
| ea_base_i | input | 32 | Effective-address base term |
| ea_index_i | input | 32 | Effective-address index term |
| use_index_i | input | 1 | Include the index term |
| ea_disp_i | input | 32 | Effective-address displacement term |
| base_we_i | input | 1 | Segment base write enable |
| base_widx_i | input | 3 | Segment base slot to write |
| base_wdata_i | input | 32 | Segment base write value |
| out_valid_o | output | 1 | Result valid |
| linear_o | output | 32 | Linear address |
| phys_o | output | 24 | Physical address |
| needs_paging_o | output | 1 | Linear address needs page translation |

## Verification
A segment base write and a protected-mode translation that reads the same slot can happen in the same cycle. The bench sets this up by driving `base_we_i` and `in_valid_i` together for slot 3. The result must come from the old base. A second translation on the next request must then show the new base. A write to slot 6, which is not a real slot, is checked by translating through slot 6 after the write and expecting a base of zero.

// File: rtl/seg_agen_pkg.sv
package seg_agen_pkg;
  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned PHYS_W    = 24;
  localparam int unsigned REAL_W    = 20;
  localparam int unsigned SEL_W     = 16;
  localparam int unsigned SEL_SHIFT = 4;
  localparam int unsigned SEG_NUM   = 6;
  localparam int unsigned SEG_IDX_W = 3;

  typedef logic [ADDR_W-1:0]    addr_t;
  typedef logic [PHYS_W-1:0]    phys_t;
  typedef logic [SEG_IDX_W-1:0] seg_idx_t;
endpackage

// File: rtl/seg_base_file.sv
module seg_base_file #(
  parameter int unsigned NUM   = seg_agen_pkg::SEG_NUM,
  parameter int unsigned IDX_W = seg_agen_pkg::SEG_IDX_W,
  parameter int unsigned DW    = seg_agen_pkg::ADDR_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [DW-1:0]    rdata_o
);
  logic [DW-1:0] base_q [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 base_q[g] <= '0;
      else if (we_i && widx_i == IDX_W'(g))        base_q[g] <= wdata_i;
    end
  end

  // read sees pre-edge contents; out-of-range slots read zero
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM; i++)
      if (ridx_i == IDX_W'(i)) rdata_o = base_q[i];
  end
endmodule

// File: rtl/ea_adder.sv
module ea_adder #(
  parameter int unsigned W = seg_agen_pkg::ADDR_W
) (
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] index_i,
  input  logic         use_index_i,
  input  logic [W-1:0] disp_i,
  output logic [W-1:0] ea_o
);
  logic [W-1:0] idx_term;
  assign idx_term = use_index_i ? index_i : '0;
  assign ea_o     = base_i + idx_term + disp_i;
endmodule

// File: rtl/lin_xlate.sv
module lin_xlate #(
  parameter int unsigned W      = seg_agen_pkg::ADDR_W,
  parameter int unsigned REAL_W = seg_agen_pkg::REAL_W,
  parameter int unsigned SEL_W  = seg_agen_pkg::SEL_W,
  parameter int unsigned SHIFT  = seg_agen_pkg::SEL_SHIFT
) (
  input  logic             prot_i,
  input  logic [SEL_W-1:0] selector_i,
  input  logic [W-1:0]     seg_base_i,
  input  logic [W-1:0]     ea_i,
  output logic [W-1:0]     linear_o
);
  logic [W-1:0] sel_ext, real_sum, prot_sum;

  assign sel_ext  = W'(selector_i) << SHIFT;
  assign real_sum = sel_ext + ea_i;
  assign prot_sum = seg_base_i + ea_i;

  // real mode drops every carry above the 1 MB window
  assign linear_o = prot_i ? prot_sum
                           : {{(W-REAL_W){1'b0}}, real_sum[REAL_W-1:0]};
endmodule

// File: rtl/seg_agen.sv
module seg_agen
  import seg_agen_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  input  logic                 prot_mode_i,
  input  logic                 paging_en_i,
  input  logic [SEG_IDX_W-1:0] seg_idx_i,
  input  logic [SEL_W-1:0]     selector_i,
  input  logic [ADDR_W-1:0]    ea_base_i,
  input  logic [ADDR_W-1:0]    ea_index_i,
  input  logic                 use_index_i,
  input  logic [ADDR_W-1:0]    ea_disp_i,
  input  logic                 base_we_i,
  input  logic [SEG_IDX_W-1:0] base_widx_i,
  input  logic [ADDR_W-1:0]    base_wdata_i,
  output logic                 out_valid_o,
  output logic [ADDR_W-1:0]    linear_o,
  output logic [PHYS_W-1:0]    phys_o,
  output logic                 needs_paging_o
);
  addr_t seg_base, ea, linear_d;
  addr_t linear_q;
  phys_t phys_q;
  logic  valid_q, paging_q;

  seg_base_file #(.NUM(SEG_NUM), .IDX_W(SEG_IDX_W), .DW(ADDR_W)) u_bases (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (base_we_i),
    .widx_i  (base_widx_i),
    .wdata_i (base_wdata_i),
    .ridx_i  (seg_idx_i),
    .rdata_o (seg_base)
  );

  ea_adder #(.W(ADDR_W)) u_ea (
    .base_i      (ea_base_i),
    .index_i     (ea_index_i),
    .use_index_i (use_index_i),
    .disp_i      (ea_disp_i),
    .ea_o        (ea)
  );

  lin_xlate #(.W(ADDR_W), .REAL_W(REAL_W), .SEL_W(SEL_W), .SHIFT(SEL_SHIFT)) u_xlate (
    .prot_i     (prot_mode_i),
    .selector_i (selector_i),
    .seg_base_i (seg_base),
    .ea_i       (ea),
    .linear_o   (linear_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= in_valid_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      linear_q <= '0;
      phys_q   <= '0;
      paging_q <= 1'b0;
    end else if (in_valid_i) begin
      linear_q <= linear_d;
      phys_q   <= linear_d[PHYS_W-1:0];
      paging_q <= prot_mode_i & paging_en_i;
    end
  end

  assign out_valid_o    = valid_q;
  assign linear_o       = linear_q;
  assign phys_o         = phys_q;
  assign needs_paging_o = paging_q;
endmodule

// File: rtl/seg_agen_chk.sv
module seg_agen_chk
  import seg_agen_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              prot_mode_i,
  input logic              paging_en_i,
  input logic              out_valid_o,
  input logic [ADDR_W-1:0] linear_o,
  input logic [PHYS_W-1:0] phys_o,
  input logic              needs_paging_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  // R6
  valid_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> out_valid_o == $past(in_valid_i));

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !$past(in_valid_i)) |-> ($stable(linear_o) && $stable(needs_paging_o)));

  // R4
  phys_trunc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> phys_o == linear_o[PHYS_W-1:0]);

  // R2
  real_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && out_valid_o && !$past(prot_mode_i)) |->
      (linear_o[ADDR_W-1:REAL_W] == '0 && !needs_paging_o));

  // R5
  paging_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && out_valid_o) |-> needs_paging_o == $past(prot_mode_i && paging_en_i));
endmodule

bind seg_agen seg_agen_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .in_valid_i     (in_valid_i),
  .prot_mode_i    (prot_mode_i),
  .paging_en_i    (paging_en_i),
  .out_valid_o    (out_valid_o),
  .linear_o       (linear_o),
  .phys_o         (phys_o),
  .needs_paging_o (needs_paging_o)
);

// File: tb/seg_agen_tb_top.sv
module seg_agen_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  typedef struct packed {
    logic        prot;
    logic        pg;
    logic [2:0]  idx;
    logic [15:0] sel;
    logic [31:0] b;
    logic [31:0] i;
    logic        ui;
    logic [31:0] d;
    logic [31:0] lin;
    logic        np;
  } vec_t;

  // bases preloaded: s0=0x00010000 s1=0x00FF0000 s2=0xFFFFF000 s3=0x12340000
  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 3'd0, 16'h1234, 32'h10,       32'h5,  1'b1, 32'h1,        32'h0001_2356, 1'b0},
    '{1'b0, 1'b1, 3'd0, 16'hFFFF, 32'h20,       32'h0,  1'b0, 32'h0,        32'h0000_0010, 1'b0},
    '{1'b0, 1'b0, 3'd0, 16'h0000, 32'h100,      32'h55, 1'b0, 32'h1,        32'h0000_0101, 1'b0},
    '{1'b1, 1'b0, 3'd0, 16'h0000, 32'h10,       32'h20, 1'b1, 32'h3,        32'h0001_0033, 1'b0},
    '{1'b1, 1'b0, 3'd1, 16'h0000, 32'h0002_0000,32'h0,  1'b1, 32'h0,        32'h0101_0000, 1'b0},
    '{1'b1, 1'b0, 3'd2, 16'h0000, 32'h2000,     32'h0,  1'b1, 32'h0,        32'h0000_1000, 1'b0},
    '{1'b1, 1'b1, 3'd3, 16'h0000, 32'h5678,     32'h0,  1'b1, 32'h0,        32'h1234_5678, 1'b1},
    '{1'b1, 1'b0, 3'd6, 16'h0000, 32'hABCDEF,   32'h0,  1'b1, 32'h0,        32'h00AB_CDEF, 1'b0},
    '{1'b1, 1'b0, 3'd0, 16'h0000, 32'hFFFF_FFFF,32'h2,  1'b1, 32'hFFFF_FFFF,32'h0001_0000, 1'b0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0, prot_mode_i = 1'b0, paging_en_i = 1'b0;
  logic [2:0]  seg_idx_i = '0;
  logic [15:0] selector_i = '0;
  logic [31:0] ea_base_i = '0, ea_index_i = '0, ea_disp_i = '0;
  logic        use_index_i = 1'b0;
  logic        base_we_i = 1'b0;
  logic [2:0]  base_widx_i = '0;
  logic [31:0] base_wdata_i = '0;
  logic        out_valid_o, needs_paging_o;
  logic [31:0] linear_o;
  logic [23:0] phys_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  seg_agen dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_base(input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk_i);
    base_we_i = 1'b1; base_widx_i = idx; base_wdata_i = val;
    @(negedge clk_i);
    base_we_i = 1'b0;
  endtask

  task automatic set_req(input logic prot, input logic pg, input logic [2:0] idx,
                         input logic [15:0] sel, input logic [31:0] b,
                         input logic [31:0] i, input logic ui, input logic [31:0] d);
    prot_mode_i = prot; paging_en_i = pg; seg_idx_i = idx; selector_i = sel;
    ea_base_i = b; ea_index_i = i; use_index_i = ui; ea_disp_i = d;
  endtask

  // drive at negedge, result registered at next posedge, sampled at following negedge
  task automatic xlate(input logic prot, input logic pg, input logic [2:0] idx,
                       input logic [15:0] sel, input logic [31:0] b,
                       input logic [31:0] i, input logic ui, input logic [31:0] d);
    @(negedge clk_i);
    set_req(prot, pg, idx, sel, b, i, ui, d);
    in_valid_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    errors++;
    $display("FAIL R6 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R8 reset state
    chk("R8 out_valid", 32'(out_valid_o), 32'h0);
    chk("R8 linear", linear_o, 32'h0);
    chk("R8 phys", 32'(phys_o), 32'h0);
    chk("R8 paging", 32'(needs_paging_o), 32'h0);
    rst_ni = 1'b1;
    // R8 bases zero after reset: slot 3 translates with base 0
    xlate(1'b1, 1'b0, 3'd3, 16'h0, 32'h44, 32'h0, 1'b0, 32'h0);
    chk("R8 base zero", linear_o, 32'h44);

    wr_base(3'd0, 32'h0001_0000);
    wr_base(3'd1, 32'h00FF_0000);
    wr_base(3'd2, 32'hFFFF_F000);
    wr_base(3'd3, 32'h1234_0000);

    for (int k = 0; k < NVEC; k++) begin
      xlate(VECS[k].prot, VECS[k].pg, VECS[k].idx, VECS[k].sel,
            VECS[k].b, VECS[k].i, VECS[k].ui, VECS[k].d);
      chk("R6 valid", 32'(out_valid_o), 32'h1);
      chk(VECS[k].prot ? "R1 R3 linear" : "R1 R2 linear", linear_o, VECS[k].lin);
      chk("R4 phys", 32'(phys_o), {8'h0, VECS[k].lin[23:0]});
      chk("R5 paging", 32'(needs_paging_o), 32'(VECS[k].np));
    end

    // R6: valid drops, outputs hold while inputs change without in_valid
    @(negedge clk_i);
    set_req(1'b1, 1'b1, 3'd1, 16'h0, 32'h777, 32'h0, 1'b0, 32'h0);
    @(negedge clk_i);
    chk("R6 valid low", 32'(out_valid_o), 32'h0);
    chk("R6 hold linear", linear_o, 32'h0001_0000);
    chk("R6 hold paging", 32'(needs_paging_o), 32'h0);

    // R7: same-cycle write and translation of slot 3 uses old base
    @(negedge clk_i);
    set_req(1'b1, 1'b0, 3'd3, 16'h0, 32'h10, 32'h0, 1'b0, 32'h0);
    in_valid_i = 1'b1;
    base_we_i = 1'b1; base_widx_i = 3'd3; base_wdata_i = 32'h0050_0000;
    @(negedge clk_i);
    in_valid_i = 1'b0; base_we_i = 1'b0;
    chk("R7 old base", linear_o, 32'h1234_0010);
    xlate(1'b1, 1'b0, 3'd3, 16'h0, 32'h10, 32'h0, 1'b0, 32'h0);
    chk("R7 new base", linear_o, 32'h0050_0010);

    // R7: slot 6 write ignored
    wr_base(3'd6, 32'h0090_0000);
    xlate(1'b1, 1'b0, 3'd6, 16'h0, 32'h8, 32'h0, 1'b0, 32'h0);
    chk("R7 slot6 ignored", linear_o, 32'h8);

    // R5: real mode with paging enable stays unflagged; protected with paging flags
    xlate(1'b0, 1'b1, 3'd3, 16'hF000, 32'h0, 32'h0, 1'b0, 32'h0);
    chk("R5 real no paging", 32'(needs_paging_o), 32'h0);
    chk("R2 real linear", linear_o, 32'h000F_0000);
    xlate(1'b1, 1'b1, 3'd2, 16'h0, 32'h0, 32'h0, 1'b0, 32'h0);
    chk("R5 prot paging", 32'(needs_paging_o), 32'h1);
    chk("R4 phys", 32'(phys_o), 32'h00FF_F000);

    // R8: asynchronous reset mid-run clears outputs
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R8 async out_valid", 32'(out_valid_o), 32'h0);
    chk("R8 async linear", linear_o, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule